// File: doc/BRIEF.md
# Depth-Cascade Token Controller for a FIFO Slice

This block is the control for one slice of a deeper buffer built by chaining several FIFO slices in a ring. Every slice keeps two ownership bits, one for the right to write and one for the right to read. A slice turns a write enable into a storage write only while it owns the write token, and a read enable into a storage read only while it owns the read token. When the slice writes or reads its last physical location, it hands the matching token to its neighbour by raising an expansion output for one cycle.

A strap input chooses which slice begins with both tokens. A mode input chooses between chained operation and standalone operation. In standalone operation the slice keeps both tokens for good, and the pin that carries the write hand-off pulse shows the half-full flag that the flag logic supplies. The block produces the storage strobes and the write and read addresses, and it permits the shared output bus to be driven only by the slice that owns the read token. The storage array and the flag thresholds sit outside this block. Chain-wide empty and full flags are formed outside the block by combining the flags of all slices.

The slice works in a single clock domain. The reset is synchronous and active low. DEPTH must be at least 2.

Top module: `cascade_slice`

## Requirements
- R1: During reset both address pointers clear to 0. With chainMode=1, the slice ends reset owning both tokens if firstLoadN=0 and owning neither token if firstLoadN=1. With chainMode=0, it owns both tokens.
- R2: memWrite equals wrEn AND wrOwn. Each write advances memWrAddr by one, and a write at address DEPTH-1 returns it to 0.
- R3: memRead equals rdEn AND rdOwn. Each read advances memRdAddr by one, and a read at address DEPTH-1 returns it to 0.
- R4: With chainMode=1, the write hand-off pulse is high for exactly the cycle in which a write hits address DEPTH-1. wrOwn falls at the following edge unless wrXIn is high in that same cycle.
- R5: With chainMode=1, rdXOut is high for exactly the cycle in which a read hits address DEPTH-1. rdOwn falls at the following edge unless rdXIn is high in that same cycle.
- R6: With chainMode=1, a high level on wrXIn (or rdXIn) during a cycle gives the slice the write (or read) token at the next rising edge. The first access after that uses the pointer value the slice left off at, which is 0 after a full pass.
- R7: An enable given while the matching token is not owned causes no strobe and leaves the matching address unchanged.
- R8: dataDrive equals outEn AND rdOwn.
- R9: wrXOutHf carries the write hand-off pulse when chainMode=1 and carries halfFullIn when chainMode=0.
- R10: With chainMode=0, both tokens stay owned through every pointer wrap, and rdXOut stays 0.
- R11: In a single-slice ring (the write hand-off output fed back to wrXIn), writes continue with no idle cycle across a wrap, and the address sequence runs 0..DEPTH-1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| chainMode | input | 1 | 1 = chained in a ring, 0 = standalone |
| firstLoadN | input | 1 | Strap; low marks the slice that starts with both tokens |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| outEn | input | 1 | Request to drive the shared output bus |
| wrXIn | input | 1 | Write hand-off pulse from the previous slice |
| rdXIn | input | 1 | Read hand-off pulse from the previous slice |
| halfFullIn | input | 1 | Half-full flag from the flag logic |
| wrXOutHf | output | 1 | Write hand-off pulse (chained) or half-full flag (standalone) |
| rdXOut | output | 1 | Read hand-off pulse to the next slice |
| memWrite | output | 1 | Storage write strobe |
| memWrAddr | output | $clog2(DEPTH) | Storage write address |
| memRead | output | 1 | Storage read strobe |
| memRdAddr | output | $clog2(DEPTH) | Storage read address |
| dataDrive | output | 1 | Enable for the shared output drivers |
| wrOwn | output | 1 | Slice owns the write token |
| rdOwn | output | 1 | Slice owns the read token |

## Verification
A wrong token bit shows at the ports in the same cycle as the next enable. Either a strobe appears on a slice that should be idle, or a strobe is missing on the owner, and dataDrive follows the read token without any delay. A pointer that is off by one moves the hand-off pulse to the wrong cycle, so the error appears within one pass of DEPTH accesses as a pulse that comes early or late and a token that moves at the wrong edge. The bench therefore compares the strobes, the addresses, the pulses and the drive enable in every cycle of a hand-off sequence. It also checks the strap, the standalone mode and the self-looped ring.

// File: rtl/cslice_pkg.sv
package cslice_pkg;
  // Strobes from the token control to the pointer datapath
  typedef struct packed {
    logic wrStep;
    logic rdStep;
  } slice_strobe_t;

  // Pointer position reported back to the token control
  typedef struct packed {
    logic wrAtLast;
    logic rdAtLast;
  } slice_pos_t;

  localparam int DIR_COUNT = 2;
  localparam int DIR_WR    = 0;
  localparam int DIR_RD    = 1;
endpackage

// File: rtl/cslice_token.sv
module cslice_token (
  input  logic clk,
  input  logic rstN,
  input  logic chainMode,
  input  logic firstLoadN,
  input  logic reqEn,
  input  logic atLast,
  input  logic xIn,
  output logic own,
  output logic step,
  output logic xOut
);
  logic ownQ;

  assign own  = ownQ;
  assign step = reqEn & ownQ;
  assign xOut = step & atLast & chainMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownQ <= !chainMode || !firstLoadN;
    end else if (!chainMode) begin
      ownQ <= 1'b1;
    end else begin
      ownQ <= (ownQ & ~xOut) | xIn;
    end
  end

  AST_TOKEN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (xOut && !xIn) |=> !own);                                        // R4
  AST_TOKEN_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (chainMode && xIn) |=> own);                                     // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    xOut |=> !xOut);                                                 // R4
  AST_STANDALONE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !chainMode |=> own);                                             // R10
endmodule

// File: rtl/cslice_ctrl.sv
module cslice_ctrl
  import cslice_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          chainMode,
  input  logic          firstLoadN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          wrXIn,
  input  logic          rdXIn,
  input  slice_pos_t    pos,
  output slice_strobe_t strobe,
  output logic          wrOwn,
  output logic          rdOwn,
  output logic          wrXOut,
  output logic          rdXOut
);
  logic [DIR_COUNT-1:0] enVec;
  logic [DIR_COUNT-1:0] lastVec;
  logic [DIR_COUNT-1:0] xInVec;
  logic [DIR_COUNT-1:0] ownVec;
  logic [DIR_COUNT-1:0] stepVec;
  logic [DIR_COUNT-1:0] xOutVec;

  assign enVec[DIR_WR]   = wrEn;
  assign enVec[DIR_RD]   = rdEn;
  assign lastVec[DIR_WR] = pos.wrAtLast;
  assign lastVec[DIR_RD] = pos.rdAtLast;
  assign xInVec[DIR_WR]  = wrXIn;
  assign xInVec[DIR_RD]  = rdXIn;

  for (genvar d = 0; d < DIR_COUNT; d++) begin : g_dir
    cslice_token u_token (
      .clk       (clk),
      .rstN      (rstN),
      .chainMode (chainMode),
      .firstLoadN(firstLoadN),
      .reqEn     (enVec[d]),
      .atLast    (lastVec[d]),
      .xIn       (xInVec[d]),
      .own       (ownVec[d]),
      .step      (stepVec[d]),
      .xOut      (xOutVec[d])
    );
  end

  assign strobe.wrStep = stepVec[DIR_WR];
  assign strobe.rdStep = stepVec[DIR_RD];
  assign wrOwn         = ownVec[DIR_WR];
  assign rdOwn         = ownVec[DIR_RD];
  assign wrXOut        = xOutVec[DIR_WR];
  assign rdXOut        = xOutVec[DIR_RD];

  AST_RD_HANDOFF_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (rdXOut && !rdXIn) |=> !rdOwn);                                  // R5
  AST_STANDALONE_NO_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !chainMode |-> !rdXOut);                                         // R10
endmodule

// File: rtl/cslice_ptrs.sv
module cslice_ptrs
  import cslice_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  slice_strobe_t strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output slice_pos_t    pos
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DIR_COUNT-1:0] stepVec;
  logic [DIR_COUNT-1:0] lastVec;
  logic [AW-1:0]        ptr [DIR_COUNT];

  assign stepVec[DIR_WR] = strobe.wrStep;
  assign stepVec[DIR_RD] = strobe.rdStep;

  for (genvar d = 0; d < DIR_COUNT; d++) begin : g_ptr
    assign lastVec[d] = (ptr[d] == LAST_IDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptr[d] <= '0;
      end else if (stepVec[d]) begin
        ptr[d] <= lastVec[d] ? '0 : ptr[d] + AW'(1);
      end
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      (stepVec[d] && ptr[d] == LAST_IDX) |=> (ptr[d] == '0));        // R2
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
      (stepVec[d] && ptr[d] != LAST_IDX) |=> (ptr[d] == $past(ptr[d]) + AW'(1))); // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !stepVec[d] |=> $stable(ptr[d]));                              // R7
  end

  assign wrAddr       = ptr[DIR_WR];
  assign rdAddr       = ptr[DIR_RD];
  assign pos.wrAtLast = lastVec[DIR_WR];
  assign pos.rdAtLast = lastVec[DIR_RD];
endmodule

// File: rtl/cascade_slice.sv
module cascade_slice
  import cslice_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          chainMode,
  input  logic          firstLoadN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          outEn,
  input  logic          wrXIn,
  input  logic          rdXIn,
  input  logic          halfFullIn,
  output logic          wrXOutHf,
  output logic          rdXOut,
  output logic          memWrite,
  output logic [AW-1:0] memWrAddr,
  output logic          memRead,
  output logic [AW-1:0] memRdAddr,
  output logic          dataDrive,
  output logic          wrOwn,
  output logic          rdOwn
);
  slice_strobe_t strobe;
  slice_pos_t    pos;
  logic          wrXPulse;

  cslice_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chainMode (chainMode),
    .firstLoadN(firstLoadN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .wrXIn     (wrXIn),
    .rdXIn     (rdXIn),
    .pos       (pos),
    .strobe    (strobe),
    .wrOwn     (wrOwn),
    .rdOwn     (rdOwn),
    .wrXOut    (wrXPulse),
    .rdXOut    (rdXOut)
  );

  cslice_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrAddr(memWrAddr),
    .rdAddr(memRdAddr),
    .pos   (pos)
  );

  assign memWrite  = strobe.wrStep;
  assign memRead   = strobe.rdStep;
  assign dataDrive = outEn & rdOwn;
  assign wrXOutHf  = chainMode ? wrXPulse : halfFullIn;

  AST_WR_PULSE_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (chainMode && wrXOutHf) |-> (memWrite && memWrAddr == AW'(DEPTH - 1))); // R4
  AST_RD_PULSE_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    rdXOut |-> (memRead && memRdAddr == AW'(DEPTH - 1)));           // R5
endmodule

// File: tb/cascade_slice_bench.sv
module cascade_slice_bench;
  localparam int DEPTH = 4;
  localparam int AW = 2;
  localparam int NVEC = 13;
  // {wrEn, rdEn, outEn, wrXIn, rdXIn | memWrite, wrAddr[1:0], memRead, rdAddr[1:0], wrX, rdX, dataDrive}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b10100_1_00_0_00_0_0_1,
    14'b11000_1_01_1_00_0_0_0,
    14'b00100_0_10_0_01_0_0_1,
    14'b10000_1_10_0_01_0_0_0,
    14'b11100_1_11_1_01_1_0_1,
    14'b10000_0_00_0_10_0_0_0,
    14'b01100_0_00_1_10_0_0_1,
    14'b01100_0_00_1_11_0_1_1,
    14'b11100_0_00_0_00_0_0_0,
    14'b00010_0_00_0_00_0_0_0,
    14'b10100_1_00_0_00_0_0_0,
    14'b01001_0_01_0_00_0_0_0,
    14'b01100_0_01_1_00_0_0_1
  };

  logic clk = 1'b0;
  logic rstN, chainMode, firstLoadN, wrEn, rdEn, outEn, wrXInTb, rdXIn, halfFullIn;
  logic loopWr;
  logic wrXIn;
  logic wrXOutHf, rdXOut, memWrite, memRead, dataDrive, wrOwn, rdOwn;
  logic [AW-1:0] memWrAddr, memRdAddr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign wrXIn = loopWr ? wrXOutHf : wrXInTb;

  cascade_slice #(.DEPTH(DEPTH)) u_cascade_slice (
    .clk(clk), .rstN(rstN), .chainMode(chainMode), .firstLoadN(firstLoadN),
    .wrEn(wrEn), .rdEn(rdEn), .outEn(outEn), .wrXIn(wrXIn), .rdXIn(rdXIn),
    .halfFullIn(halfFullIn), .wrXOutHf(wrXOutHf), .rdXOut(rdXOut),
    .memWrite(memWrite), .memWrAddr(memWrAddr), .memRead(memRead),
    .memRdAddr(memRdAddr), .dataDrive(dataDrive), .wrOwn(wrOwn), .rdOwn(rdOwn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    wrEn = 0; rdEn = 0; outEn = 0; wrXInTb = 0; rdXIn = 0;
  endtask

  task automatic doReset(input logic chain, input logic fl);
    @(negedge clk);
    rstN = 0; chainMode = chain; firstLoadN = fl; idle();
    repeat (2) @(negedge clk);
    rstN = 1;
    #5;
  endtask

  initial begin
    rstN = 0; chainMode = 1; firstLoadN = 0; halfFullIn = 0; loopWr = 0;
    idle();

    // Reset of the first slice in a chain
    doReset(1'b1, 1'b0);
    chk("R1 first wrOwn", wrOwn, 1);
    chk("R1 first rdOwn", rdOwn, 1);
    chk("R1 wrAddr", memWrAddr, 0);
    chk("R1 rdAddr", memRdAddr, 0);

    // Table walk: hand-off sequence on the first slice (halfFullIn held high, masked in chain mode)
    halfFullIn = 1;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {wrEn, rdEn, outEn, wrXInTb, rdXIn} = VEC[i][13:9];
      #5;
      chk($sformatf("R2 memWrite v%0d", i), memWrite, VEC[i][8]);
      chk($sformatf("R2 wrAddr v%0d", i), memWrAddr, VEC[i][7:6]);
      chk($sformatf("R3 memRead v%0d", i), memRead, VEC[i][5]);
      chk($sformatf("R3 rdAddr v%0d", i), memRdAddr, VEC[i][4:3]);
      chk($sformatf("R4 R9 wrXOutHf v%0d", i), wrXOutHf, VEC[i][2]);
      chk($sformatf("R5 rdXOut v%0d", i), rdXOut, VEC[i][1]);
      chk($sformatf("R8 dataDrive v%0d", i), dataDrive, VEC[i][0]);
    end
    halfFullIn = 0;

    // Slice without the strap: no tokens, enables ignored, token arrives by pulse
    doReset(1'b1, 1'b1);
    chk("R1 other wrOwn", wrOwn, 0);
    chk("R1 other rdOwn", rdOwn, 0);
    @(negedge clk); wrEn = 1; rdEn = 1; outEn = 1; #5;
    chk("R7 no write strobe", memWrite, 0);
    chk("R7 no read strobe", memRead, 0);
    chk("R8 no drive without token", dataDrive, 0);
    @(negedge clk); wrEn = 0; rdEn = 0; wrXInTb = 1; #5;
    chk("R7 wrAddr held", memWrAddr, 0);
    chk("R6 token not yet taken", wrOwn, 0);
    @(negedge clk); wrXInTb = 0; wrEn = 1; #5;
    chk("R6 wrOwn after pulse", wrOwn, 1);
    chk("R6 write strobe", memWrite, 1);
    chk("R6 write at address 0", memWrAddr, 0);
    chk("R6 read token untouched", rdOwn, 0);
    @(negedge clk); idle(); #5;
    chk("R2 wrAddr advanced", memWrAddr, 1);

    // Standalone mode
    doReset(1'b0, 1'b1);
    chk("R1 standalone wrOwn", wrOwn, 1);
    chk("R1 standalone rdOwn", rdOwn, 1);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); idle(); wrEn = 1; rdEn = 1; #5;
      chk($sformatf("R10 wrAddr s%0d", i), memWrAddr, i);
      chk("R9 shows half-full (0)", wrXOutHf, 0);
      chk("R10 no rdXOut", rdXOut, 0);
    end
    @(negedge clk); idle(); halfFullIn = 1; #5;
    chk("R10 wrOwn kept", wrOwn, 1);
    chk("R10 rdOwn kept", rdOwn, 1);
    chk("R10 wrAddr wrapped", memWrAddr, 0);
    chk("R9 shows half-full (1)", wrXOutHf, 1);
    halfFullIn = 0;

    // Single-slice ring
    doReset(1'b1, 1'b0);
    loopWr = 1;
    for (int i = 0; i <= DEPTH; i++) begin
      @(negedge clk); idle(); wrEn = 1; #5;
      chk($sformatf("R11 write strobe r%0d", i), memWrite, 1);
      chk($sformatf("R11 wrAddr r%0d", i), memWrAddr, i % DEPTH);
      chk($sformatf("R9 ring pulse r%0d", i), wrXOutHf, (i % DEPTH) == DEPTH - 1);
    end
    @(negedge clk); idle(); #5;
    chk("R11 token retained", wrOwn, 1);
    loopWr = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule